// File: doc/BRIEF.md
# SDRAM Bank State Checker

This block watches the command, bank-select and address pins of a four-bank SDRAM bus without driving anything. It decodes the command on every enabled clock edge and keeps its own estimate of each bank's state: idle, row open, read burst, write burst, write recovery or precharging. It also holds the timing windows that follow a precharge, a write, a refresh and a burst. A command that the current state does not allow produces a one-cycle violation pulse, together with an error code for the kind of breach and the bank it concerns. After a violation the checker keeps tracking, so later breaches are still reported.

It is placed next to a memory controller in simulation or in a debug build. The precharge, refresh and write-recovery windows are parameters counted in clock edges. The burst length is taken from the mode-register load op-code. Edges that follow a low clock-enable sample are skipped, and all windows freeze during them.

Top module: `sdram_bank_checker`

## Requirements
- R1: Commands are decoded from {cs_n, ras_n, cas_n, we_n}: 1xxx deselect, 0111 NOP, 0110 burst stop, 0101 read, 0100 write, 0011 activate, 0010 precharge, 0001 refresh, 0000 mode load. After reset all banks are idle, the burst length is 1, and viol, err_code and err_bank are 0.
- R2: A read or write to a bank that is idle or precharging raises code 1 and reports bank = ba. The bank state does not change.
- R3: An activate to a bank that is neither idle nor precharging raises code 2. An activate to a precharging bank fewer than T_RP edges after its precharge raises code 3. An activate exactly T_RP edges after the precharge is legal. After a violating activate the bank is treated as row open.
- R4: A precharge with addr[10] high acts on every bank. With addr[10] low it acts only on bank ba, and the other banks keep their open rows.
- R5: Refresh and mode load need all banks idle. Otherwise they raise code 4 with err_bank set to the lowest-numbered non-idle bank. A rejected mode load leaves the burst length unchanged.
- R6: After a legal refresh, any command other than NOP or deselect on edges 1 to T_RC-1 after it raises code 5 with bank = ba. Edge T_RC is free again.
- R7: Burst stop returns a bank in a read or write burst to row open, and a write stopped this way skips write recovery. Burst stop while the banks are idle has no effect.
- R8: A legal read or write cuts off the burst running on any other bank. A cut-off read goes to row open, or to precharging if it carried auto precharge. A cut-off write enters write recovery.
- R9: A legal mode load sets the burst length from addr[2:0]: 0→1, 1→2, 2→4, 3→8, 7→full page (the burst never ends on its own). A read or write issued with addr[10] high precharges its bank when the burst ends.
- R10: A write burst that ends is followed by T_WR edges of write recovery. A precharge to a bank in recovery raises code 6, and the bank still starts precharging.
- R11: An edge whose preceding edge sampled cke low is ignored: no violation is reported, no state changes and no window advances.
- R12: NOP and deselect never raise a violation and change no bank state. Each violating command gives exactly one cycle of viol with a nonzero err_code. When viol is low, err_code and err_bank are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank select |
| addr | input | ADDR_W | Address / op-code bus |
| viol | output | 1 | One-cycle violation pulse |
| err_code | output | 3 | Violation type (0 when none) |
| err_bank | output | BA_W | Bank the violation concerns |

## Verification
The hardest state to reach from the ports is the edge at which a burst ends by itself, because nothing on the bus marks it. That moment decides whether a bank is bursting, in write recovery, precharging or row open. The stimulus first programs a known burst length with a mode load. It then places a probe command on one exact edge after the burst starts. A precharge landing on the first recovery edge of a naturally ended write, and an activate landing on the edge where an auto-precharge read finishes, pin the burst length and the end-of-burst transition to a single cycle.

// File: rtl/sdram_bank_checker.sv
module sdram_bank_checker #(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 12,
  parameter int AP_BIT = 10,
  parameter int T_RP   = 3,
  parameter int T_RC   = 7,
  parameter int T_WR   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              viol,
  output logic [2:0]        err_code,
  output logic [BA_W-1:0]   err_bank
);

  localparam int NB   = 1 << BA_W;
  localparam int TM1  = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int TM2  = (TM1 > T_WR) ? TM1 : T_WR;
  localparam int TMAX = (TM2 > 8) ? TM2 : 8;
  localparam int CW   = $clog2(TMAX);
  localparam logic [CW-1:0] RP1 = CW'(T_RP - 1);
  localparam logic [CW-1:0] WR1 = CW'(T_WR - 1);
  localparam logic [CW-1:0] RC1 = CW'(T_RC - 1);

  localparam logic [2:0] E_CLOSED = 3'd1;
  localparam logic [2:0] E_OPEN   = 3'd2;
  localparam logic [2:0] E_TRP    = 3'd3;
  localparam logic [2:0] E_BUSY   = 3'd4;
  localparam logic [2:0] E_TRC    = 3'd5;
  localparam logic [2:0] E_TWR    = 3'd6;

  typedef enum logic [2:0] {B_IDLE, B_OPEN, B_READ, B_WRITE, B_RECOV, B_PRECH} bstate_t;

  bstate_t       st [NB];
  logic [CW-1:0] cnt [NB];
  logic [NB-1:0] apf;
  logic [2:0]    blc;
  logic [CW-1:0] rc;
  logic          cke_q;

  bstate_t       es [NB];
  logic [CW-1:0] ec [NB];
  bstate_t       ns [NB];
  logic [CW-1:0] nc [NB];
  logic [NB-1:0] nap;

  wire [2:0] op     = {ras_n, cas_n, we_n};
  wire       sel    = !cs_n;
  wire       is_nop = sel && op == 3'b111;
  wire       is_bst = sel && op == 3'b110;
  wire       is_rd  = sel && op == 3'b101;
  wire       is_wr  = sel && op == 3'b100;
  wire       is_act = sel && op == 3'b011;
  wire       is_pre = sel && op == 3'b010;
  wire       is_ref = sel && op == 3'b001;
  wire       is_mrs = sel && op == 3'b000;
  wire       is_cmd = sel && !is_nop;
  wire       ap     = addr[AP_BIT];
  wire       en     = cke_q;
  wire       unused_addr = ^addr;

  wire          fp   = blc == 3'b111;
  wire [CW-1:0] blm1 = blc[2] ? '0 : CW'((32'd1 << blc[1:0]) - 32'd1);

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      es[i] = st[i];
      ec[i] = (cnt[i] != '0) ? cnt[i] - 1'b1 : '0;
      case (st[i])
        B_PRECH: if (cnt[i] == '0) es[i] = B_IDLE;
        B_READ:  if (cnt[i] == '0 && !fp) begin es[i] = apf[i] ? B_PRECH : B_OPEN; ec[i] = RP1; end
        B_WRITE: if (cnt[i] == '0 && !fp) begin es[i] = B_RECOV; ec[i] = WR1; end
        B_RECOV: if (cnt[i] == '0) begin es[i] = apf[i] ? B_PRECH : B_OPEN; ec[i] = RP1; end
        default: ;
      endcase
    end
  end

  logic          any_busy, any_rec;
  logic [BA_W-1:0] first_busy, first_rec;
  always_comb begin
    any_busy = 1'b0; any_rec = 1'b0;
    first_busy = '0; first_rec = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (es[i] != B_IDLE)  begin any_busy = 1'b1; first_busy = BA_W'(i); end
      if (es[i] == B_RECOV) begin any_rec  = 1'b1; first_rec  = BA_W'(i); end
    end
  end

  wire bstate_t tgt  = es[ba];
  wire          open = tgt inside {B_OPEN, B_READ, B_WRITE, B_RECOV};

  logic [2:0]      code;
  logic [BA_W-1:0] bank;
  always_comb begin
    code = '0;
    bank = ba;
    if (is_cmd && rc != '0)                    code = E_TRC;
    else if ((is_rd || is_wr) && !open)        code = E_CLOSED;
    else if (is_act && tgt == B_PRECH)         code = E_TRP;
    else if (is_act && tgt != B_IDLE)          code = E_OPEN;
    else if (is_pre && ap && any_rec)          begin code = E_TWR; bank = first_rec; end
    else if (is_pre && !ap && tgt == B_RECOV)  code = E_TWR;
    else if ((is_ref || is_mrs) && any_busy)   begin code = E_BUSY; bank = first_busy; end
  end

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      ns[i]  = es[i];
      nc[i]  = ec[i];
      nap[i] = apf[i];
      if ((is_rd || is_wr) && open) begin
        if (ba == BA_W'(i)) begin
          ns[i] = is_rd ? B_READ : B_WRITE; nc[i] = blm1; nap[i] = ap;
        end else if (es[i] == B_READ) begin
          ns[i] = apf[i] ? B_PRECH : B_OPEN; nc[i] = RP1;
        end else if (es[i] == B_WRITE) begin
          ns[i] = B_RECOV; nc[i] = WR1;
        end
      end else if (is_bst) begin
        if (es[i] == B_READ || es[i] == B_WRITE) ns[i] = B_OPEN;
      end else if (is_act) begin
        if (ba == BA_W'(i)) ns[i] = B_OPEN;
      end else if (is_pre) begin
        if ((ap || ba == BA_W'(i)) && es[i] != B_IDLE && es[i] != B_PRECH) begin
          ns[i] = B_PRECH; nc[i] = RP1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin st[i] <= B_IDLE; cnt[i] <= '0; end
      apf <= '0; blc <= '0; rc <= '0; cke_q <= 1'b1;
      viol <= 1'b0; err_code <= '0; err_bank <= '0;
    end else begin
      cke_q <= cke;
      if (en) begin
        for (int i = 0; i < NB; i++) begin st[i] <= ns[i]; cnt[i] <= nc[i]; end
        apf <= nap;
        if (is_ref && !any_busy) rc <= RC1;
        else if (rc != '0)       rc <= rc - 1'b1;
        if (is_mrs && !any_busy) blc <= addr[2:0];
        viol     <= code != '0;
        err_code <= code;
        err_bank <= (code != '0) ? bank : '0;
      end else begin
        viol <= 1'b0; err_code <= '0; err_bank <= '0;
      end
    end
  end

  a_r11_skip_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_q |=> !viol);

  a_r12_quiet_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && (cs_n || op == 3'b111)) |=> (!viol && err_code == 3'd0));

  a_r2_closed_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && rc == '0 && !cs_n && (op == 3'b101 || op == 3'b100) && st[ba] == B_IDLE)
      |=> (viol && err_code == 3'd1));

  a_r6_refresh_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_q && rc != '0 && !cs_n && op != 3'b111) |=> (viol && err_code == 3'd5));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    a_r3_prech_window: assert property (@(posedge clk) disable iff (!rst_n)
      (st[g] == B_PRECH) |-> (cnt[g] <= RP1));
  end

endmodule

// File: tb/sdram_bank_checker_test.sv
`timescale 1ns/1ps
module sdram_bank_checker_test;

  localparam logic [3:0] DSL = 4'b1111, NOP = 4'b0111, BST = 4'b0110, RD = 4'b0101,
                         WR = 4'b0100, ACT = 4'b0011, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam logic [11:0] AP = 12'h400;

  logic clk = 1'b0, rst_n = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic [11:0] addr = '0;
  logic viol;
  logic [2:0] err_code;
  logic [1:0] err_bank;

  int cyc = 0, checks = 0, errors = 0;
  bit done = 1'b0;

  typedef struct { int due; int code; int bank; string tag; } exp_t;
  exp_t q[$];

  sdram_bank_checker uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .viol(viol), .err_code(err_code), .err_bank(err_bank)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input logic k, input logic [3:0] c, input logic [1:0] b,
                      input logic [11:0] a, input int ecode, input int ebank, input string tag);
    exp_t it;
    @(negedge clk);
    cke = k; {cs_n, ras_n, cas_n, we_n} = c; ba = b; addr = a;
    it.due = cyc + 1; it.code = ecode; it.bank = ebank; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, NOP, 2'd0, 12'h000, 0, 0, tag);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if (viol !== (it.code != 0) || err_code !== 3'(it.code) ||
          (it.code != 0 && err_bank !== 2'(it.bank))) begin
        errors++;
        $display("FAIL %s: viol=%0b code=%0d bank=%0d, expected code=%0d bank=%0d",
                 it.tag, viol, err_code, err_bank, it.code, it.bank);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (viol !== 1'b0 || err_code !== 3'd0 || err_bank !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset: viol=%0b code=%0d bank=%0d, expected 0 0 0", viol, err_code, err_bank);
    end
    step(1, NOP, 0, 12'h000, 0, 0, "R1 nop after reset");
    step(1, RD,  1, 12'h000, 1, 1, "R2 read idle bank");
    step(1, WR,  3, 12'h000, 1, 3, "R2 write idle bank");
    step(1, BST, 0, 12'h000, 0, 0, "R7 burst stop when idle");
    step(1, MRS, 0, 12'h002, 0, 0, "R9 load burst length 4");
    step(1, ACT, 2, 12'h000, 0, 0, "R3 open bank2");
    step(1, ACT, 2, 12'h000, 2, 2, "R3 activate open bank");
    step(1, REF, 0, 12'h000, 4, 2, "R5 refresh with open bank");
    step(1, ACT, 0, 12'h000, 0, 0, "R3 open bank0");
    step(1, MRS, 0, 12'h000, 4, 0, "R5 mode load lowest busy bank");
    step(1, RD,  0, 12'h000, 0, 0, "R8 read bank0");
    step(1, WR,  2, 12'h000, 0, 0, "R8 write cuts read");
    step(1, RD,  0, 12'h000, 0, 0, "R8 read cuts write");
    step(1, PRE, 2, 12'h000, 6, 2, "R8 cut write in recovery");
    step(1, BST, 0, 12'h000, 0, 0, "R7 stop read");
    step(1, WR,  0, 12'h000, 0, 0, "R7 write bank0");
    step(1, BST, 0, 12'h000, 0, 0, "R7 stop write");
    idle(2, "R12 nop");
    step(1, PRE, 0, 12'h000, 0, 0, "R7 stopped write skips recovery");
    step(1, RD,  0, 12'h000, 1, 0, "R2 read precharging bank");
    step(1, ACT, 0, 12'h000, 3, 0, "R3 activate inside tRP");
    step(1, PRE, 0, 12'h000, 0, 0, "R12 tracking after violation");
    idle(2, "R12 nop");
    step(1, ACT, 0, 12'h000, 0, 0, "R3 activate at tRP");
    step(1, WR,  0, 12'h000, 0, 0, "R10 write bank0");
    idle(3, "R12 nop");
    step(1, PRE, 0, 12'h000, 6, 0, "R10 precharge in write recovery");
    step(1, ACT, 2, 12'h000, 0, 0, "R4 open bank2");
    step(1, RD,  2, 12'h000, 0, 0, "R4 single precharge kept bank2");
    step(1, RD,  0, 12'h000, 1, 0, "R2 read closed bank0");
    step(1, PRE, 0, AP,      0, 0, "R4 precharge all");
    step(1, RD,  2, 12'h000, 1, 2, "R4 bank2 closed by precharge all");
    idle(1, "R12 nop");
    step(1, REF, 0, 12'h000, 0, 0, "R6 legal refresh");
    step(1, NOP, 0, 12'h000, 0, 0, "R6 nop in hold");
    step(1, DSL, 0, 12'h000, 0, 0, "R12 deselect in hold");
    step(1, BST, 3, 12'h000, 5, 3, "R6 command in hold");
    idle(2, "R6 nop");
    step(1, BST, 1, 12'h000, 5, 1, "R6 last hold edge");
    step(1, MRS, 0, 12'h007, 0, 0, "R6 edge tRC free, R9 full page");
    step(1, ACT, 1, 12'h000, 0, 0, "R9 open bank1");
    step(1, RD,  1, AP,      0, 0, "R9 full page read");
    idle(10, "R9 nop");
    step(1, ACT, 1, 12'h000, 2, 1, "R9 full page still bursting");
    step(1, BST, 0, 12'h000, 0, 0, "R7 stop");
    step(1, PRE, 1, 12'h000, 0, 0, "R4 close bank1");
    idle(2, "R12 nop");
    step(1, MRS, 0, 12'h001, 0, 0, "R9 load burst length 2");
    step(1, ACT, 3, 12'h000, 0, 0, "R9 open bank3");
    step(1, RD,  3, AP,      0, 0, "R9 read with auto precharge");
    idle(1, "R9 nop");
    step(1, ACT, 3, 12'h000, 3, 3, "R9 auto precharge at burst end");
    step(0, NOP, 0, 12'h000, 0, 0, "R11 cke low");
    step(1, ACT, 3, 12'h000, 0, 0, "R11 ignored edge");
    step(1, ACT, 3, 12'h000, 2, 3, "R11 edge after restore");
    idle(3, "R12 nop");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule